// File: doc/BRIEF.md
# Register-Mapped Serial Port with Character Queues

This block is a small serial port that sits on a 32-bit register bus inside a larger chip. Software writes characters into a 16-entry transmit queue and reads received characters from a 16-entry receive queue. A transmitter state machine turns each queued character into an asynchronous frame on `tx_out`. A receiver state machine rebuilds frames from `rx_in` and records overrun, framing and parity errors. The bit rate is fixed when the block is built.

Software sees four word-aligned registers in a 16-byte window. It polls a status word or waits for the one-cycle interrupt pulse. That pulse fires when the receive queue gains its first character or the transmit queue drains, but only while interrupts are enabled. A write to the control register can empty either queue at once and sets the interrupt enable.

The transmitter moves through the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. In TX_IDLE it leaves when the transmit queue is not empty; it pops one character and goes to TX_START. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_PARITY after the eighth bit, or to TX_STOP if parity is off. TX_PARITY goes to TX_STOP after one bit time, and TX_STOP returns to TX_IDLE after one bit time.

The receiver moves through RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP and RX_BREAK. In RX_IDLE it goes to RX_START when it sees the line low on a 16x tick. RX_START checks the line at the middle of the start bit: it goes to RX_DATA if the line is still low and back to RX_IDLE if the line was a glitch. RX_DATA goes to RX_PARITY after eight samples, or to RX_STOP if parity is off. RX_PARITY goes to RX_STOP after one sample. RX_STOP goes to RX_IDLE if the stop bit is high, or to RX_BREAK if it is low. RX_BREAK waits for the line to go high and then returns to RX_IDLE.

Top module: `lu_uart`

## Requirements
- R1: The register is selected by `bus_addr[3:2]`:
  - 0 is receive data (read).
  - 1 is transmit data (write).
  - 2 is status (read).
  - 3 is control (write).
  
  A read updates `bus_rdata` at the clock edge that accepts it. Reading offset 1 or 3 returns 0.
- R2: The status word is {24'b0, parity error, framing error, overrun, interrupt enable, transmit full, transmit empty, receive full, receive valid}, from bit 7 down to bit 0. After reset it reads 0x04.
- R3: A write to transmit data queues only `bus_wdata[7:0]`. The transmit queue holds 16 characters, and a write while it is full is dropped. Each character is sent as one low start bit, then 8 data bits LSB first, then an even parity bit (default parameters), then one high stop bit. Each bit lasts 16*CLK_DIV cycles, and the line idles high.
- R4: The receiver samples at 16 times the bit rate and takes each bit at mid-bit. It stores each character in a 16-entry queue. A read of receive data pops the oldest character. A read when the queue is empty returns 0 and changes nothing.
- R5: A character that completes while the receive queue is full is discarded, and status bit 5 (overrun) is set.
- R6: A stop bit sampled low sets status bit 6 (framing). A parity mismatch sets status bit 7. In both cases the character is still stored.
- R7: Status bits 5 to 7 are returned by a status read and then cleared by that read.
- R8: Control bit 0 empties the transmit queue, after which status bit 2 reads 1. Control bit 1 empties the receive queue. Neither bit is stored.
- R9: Control bit 4 sets the interrupt enable, and status bit 4 mirrors it. Writing 0 to control disables interrupts.
- R10: While interrupts are enabled, `irq` gives a one-cycle pulse one cycle after the receive queue goes from empty to non-empty. It also pulses one cycle after the transmit queue goes from non-empty to empty. While interrupts are disabled it does not pulse.
- R11: After reset, `tx_out` is 1, `irq` is 0 and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rx_in | input | 1 | Serial input line |
| tx_out | output | 1 | Serial output line |
| irq | output | 1 | Interrupt pulse |

## Verification
Read data and the side effects of a read (a pop or a flag clear) take effect at the edge that accepts the access, so the bench samples them at the next falling edge. A transmitted bit is checked at the middle of its bit time, counted from the falling edge of the start bit. A received character is checked only after the bench has driven its whole stop bit, which is later than the mid-stop sample at which the receiver stores it. Interrupt pulses are counted on every falling edge, and the counts are compared only after the queue transition plus a margin.

// File: rtl/lu_pkg.sv
package lu_pkg;
    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_BREAK
    } rx_state_t;

    localparam logic [1:0] REG_RXD  = 2'd0;
    localparam logic [1:0] REG_TXD  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    localparam int OVERSAMPLE = 16;
endpackage

// File: rtl/lu_fifo.sv
module lu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt_ptr(wp);
            if (do_pop)  rp <= nxt_ptr(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && $stable(wp)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/lu_tx.sv
module lu_tx
    import lu_pkg::*;
#(
    parameter int   CLK_DIV    = 4,
    parameter bit   PARITY_EN  = 1'b1,
    parameter bit   PARITY_ODD = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       line
);
    localparam int BIT_CYC = OVERSAMPLE * CLK_DIV;
    localparam int CW      = $clog2(BIT_CYC);

    tx_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [2:0]    bcnt;
    logic [7:0]    shreg;
    logic          pbit;
    logic          bit_end;

    assign bit_end = (cnt == CW'(BIT_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (!q_empty) nxt = TX_START;
            TX_START:  if (bit_end)  nxt = TX_DATA;
            TX_DATA:   if (bit_end && bcnt == 3'd7) nxt = PARITY_EN ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end)  nxt = TX_STOP;
            TX_STOP:   if (bit_end)  nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            bcnt  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (state == TX_IDLE) begin
            cnt  <= '0;
            bcnt <= '0;
            if (!q_empty) begin
                shreg <= q_data;
                pbit  <= (^q_data) ^ PARITY_ODD;
            end
        end else begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
            if (state == TX_DATA && bit_end) begin
                shreg <= {1'b0, shreg[7:1]};
                bcnt  <= bcnt + 1'b1;
            end
        end
    end

    always_comb begin
        q_pop = 1'b0;
        line  = 1'b1;
        unique case (state)
            TX_IDLE:   q_pop = !q_empty;
            TX_START:  line  = 1'b0;
            TX_DATA:   line  = shreg[0];
            TX_PARITY: line  = pbit;
            TX_STOP:   line  = 1'b1;
            default:   line  = 1'b1;
        endcase
    end

    // R3
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && nxt == TX_DATA) |-> (cnt == CW'(BIT_CYC - 1)));
endmodule

// File: rtl/lu_rx.sv
module lu_rx
    import lu_pkg::*;
#(
    parameter int   CLK_DIV    = 4,
    parameter bit   PARITY_EN  = 1'b1,
    parameter bit   PARITY_ODD = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line,
    output logic       done,
    output logic [7:0] data,
    output logic       frame_err,
    output logic       parity_err
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    rx_state_t     state, nxt;
    logic [DW-1:0] div;
    logic          tick;
    logic [1:0]    sync;
    logic          rxs;
    logic [3:0]    scnt;
    logic [2:0]    bcnt;
    logic [7:0]    shreg;
    logic          pbit;
    logic          mid_start, bit_samp;

    assign rxs       = sync[1];
    assign tick      = (div == DW'(CLK_DIV - 1));
    assign mid_start = tick && (scnt == 4'd7);
    assign bit_samp  = tick && (scnt == 4'd15);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync <= 2'b11;
            div  <= '0;
        end else begin
            sync <= {sync[0], line};
            div  <= tick ? '0 : div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick && !rxs) nxt = RX_START;
            RX_START:  if (mid_start) nxt = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_samp && bcnt == 3'd7) nxt = PARITY_EN ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_samp) nxt = RX_STOP;
            RX_STOP:   if (bit_samp) nxt = rxs ? RX_IDLE : RX_BREAK;
            RX_BREAK:  if (rxs) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt       <= '0;
            bcnt       <= '0;
            shreg      <= '0;
            pbit       <= 1'b0;
            done       <= 1'b0;
            data       <= '0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE || (state == RX_START && scnt == 4'd7))
                    scnt <= '0;
                else
                    scnt <= scnt + 1'b1;
            end
            if (state == RX_START) bcnt <= '0;
            if (state == RX_DATA && bit_samp) begin
                shreg <= {rxs, shreg[7:1]};
                bcnt  <= bcnt + 1'b1;
            end
            if (state == RX_PARITY && bit_samp) pbit <= rxs;
            if (state == RX_STOP && bit_samp) begin
                done       <= 1'b1;
                data       <= shreg;
                frame_err  <= !rxs;
                parity_err <= PARITY_EN && ((^shreg) ^ pbit ^ PARITY_ODD);
            end
        end
    end

    // R4
    done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == RX_STOP));
endmodule

// File: rtl/lu_uart.sv
module lu_uart
    import lu_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FIFO_DEPTH = 16,
    parameter bit PARITY_EN  = 1'b1,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_in,
    output logic        tx_out,
    output logic        irq
);
    logic [1:0] reg_sel;
    logic       wr_tx, wr_ctl, rd_rx, rd_st, rd_other;

    logic       tx_empty, tx_full, tx_pop;
    logic [7:0] tx_dout;
    logic       rx_empty, rx_full;
    logic [7:0] rx_dout;

    logic       rx_done, rx_ferr, rx_perr;
    logic [7:0] rx_data;

    logic       ie_q, ovr_q, frm_q, par_q;
    logic       rx_ne_q, tx_e_q;
    logic [7:0] status;

    assign reg_sel  = bus_addr[3:2];
    assign wr_tx    = bus_sel &&  bus_wr && reg_sel == REG_TXD;
    assign wr_ctl   = bus_sel &&  bus_wr && reg_sel == REG_CTRL;
    assign rd_rx    = bus_sel && !bus_wr && reg_sel == REG_RXD;
    assign rd_st    = bus_sel && !bus_wr && reg_sel == REG_STAT;
    assign rd_other = bus_sel && !bus_wr && !rd_rx && !rd_st;

    assign status = {par_q, frm_q, ovr_q, ie_q, tx_full, tx_empty, rx_full, !rx_empty};

    lu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .flush(wr_ctl && bus_wdata[0]),
        .push(wr_tx), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_dout),
        .empty(tx_empty), .full(tx_full)
    );

    lu_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .flush(wr_ctl && bus_wdata[1]),
        .push(rx_done), .din(rx_data),
        .pop(rd_rx), .dout(rx_dout),
        .empty(rx_empty), .full(rx_full)
    );

    lu_tx #(.CLK_DIV(CLK_DIV), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .q_empty(tx_empty), .q_data(tx_dout), .q_pop(tx_pop),
        .line(tx_out)
    );

    lu_rx #(.CLK_DIV(CLK_DIV), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_rx (
        .clk(clk), .rst_n(rst_n), .line(rx_in),
        .done(rx_done), .data(rx_data),
        .frame_err(rx_ferr), .parity_err(rx_perr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            ie_q      <= 1'b0;
            ovr_q     <= 1'b0;
            frm_q     <= 1'b0;
            par_q     <= 1'b0;
            rx_ne_q   <= 1'b0;
            tx_e_q    <= 1'b1;
            irq       <= 1'b0;
        end else begin
            if (rd_rx)         bus_rdata <= rx_empty ? 32'd0 : {24'd0, rx_dout};
            else if (rd_st)    bus_rdata <= {24'd0, status};
            else if (rd_other) bus_rdata <= 32'd0;

            if (wr_ctl) ie_q <= bus_wdata[4];

            ovr_q <= (rx_done && rx_full) || (ovr_q && !rd_st);
            frm_q <= (rx_done && rx_ferr) || (frm_q && !rd_st);
            par_q <= (rx_done && rx_perr) || (par_q && !rd_st);

            rx_ne_q <= !rx_empty;
            tx_e_q  <= tx_empty;
            irq     <= ie_q && ((!rx_empty && !rx_ne_q) || (tx_empty && !tx_e_q));
        end
    end

    // R9
    ie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !bus_wdata[4]) |=> !status[4]);

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_q |=> !irq);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && !rx_done) |=> (status[7:5] == 3'b000));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_empty) |=> (bus_rdata == 32'd0));
endmodule

// File: tb/lu_uart_tb.sv
`timescale 1ns/1ps
module lu_uart_tb;
    localparam int CLK_DIV = 4;
    localparam int BIT     = 16 * CLK_DIV;
    localparam int FRAME   = 11 * BIT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_out, irq;
    logic        loop = 1'b0;
    logic        drv_line = 1'b1;
    logic        rx_line;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    bit done_flag = 0;

    assign rx_line = loop ? tx_out : drv_line;

    always #4 clk = ~clk;

    lu_uart #(.CLK_DIV(CLK_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_in(rx_line), .tx_out(tx_out), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        @(negedge clk);
        drv_line = 0; wait_clk(BIT);
        for (int i = 0; i < 8; i++) begin drv_line = d[i]; wait_clk(BIT); end
        drv_line = (^d) ^ bad_par; wait_clk(BIT);
        drv_line = !bad_stop; wait_clk(BIT);
        drv_line = 1; wait_clk(BIT);
    endtask

    task automatic test_reset;
        logic [31:0] v;
        chk("R11 tx_out idle", {31'd0, tx_out}, 32'd1);
        chk("R11 irq low", {31'd0, irq}, 32'd0);
        bus_read(4'h8, v); chk("R2 reset status", v, 32'h04);
        bus_read(4'h0, v); chk("R4 empty read", v, 32'h0);
        bus_read(4'hC, v); chk("R1 control reads zero", v, 32'h0);
        bus_read(4'h8, v); chk("R4 empty read no side effect", v, 32'h04);
    endtask

    task automatic test_frame_out;
        logic [31:0] v;
        int t;
        loop = 1;
        bus_write(4'h4, 32'h1234_56A5);
        t = 0;
        while (tx_out !== 1'b0 && t < 200) begin @(negedge clk); t++; end
        wait_clk(BIT / 2);
        chk("R3 start bit", {31'd0, tx_out}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(BIT);
            chk("R3 data bit", {31'd0, tx_out}, {31'd0, (8'hA5 >> i) & 8'h1});
        end
        wait_clk(BIT); chk("R3 parity bit", {31'd0, tx_out}, 32'd0);
        wait_clk(BIT); chk("R3 stop bit", {31'd0, tx_out}, 32'd1);
        wait_clk(BIT);
        bus_read(4'h8, v); chk("R2 rx valid status", v, 32'h05);
        bus_read(4'h0, v); chk("R4 loop char low byte", v, 32'hA5);
        bus_read(4'h8, v); chk("R4 pop empties", v, 32'h04);
    endtask

    task automatic test_order;
        logic [31:0] v;
        bus_write(4'h4, 32'h01);
        bus_write(4'h4, 32'h82);
        bus_write(4'h4, 32'hFF);
        wait_clk(3 * FRAME + 200);
        bus_read(4'h0, v); chk("R4 order 0", v, 32'h01);
        bus_read(4'h0, v); chk("R4 order 1", v, 32'h82);
        bus_read(4'h0, v); chk("R4 order 2", v, 32'hFF);
    endtask

    task automatic test_full_overrun;
        logic [31:0] v;
        for (int i = 0; i < 20; i++) bus_write(4'h4, 32'h40 + i);
        bus_read(4'h8, v); chk("R3 tx full after burst", v & 32'h0C, 32'h08);
        wait_clk(18 * FRAME);
        bus_read(4'h8, v); chk("R5 overrun and rx full", v, 32'h27);
        bus_read(4'h8, v); chk("R7 overrun cleared", v, 32'h07);
        for (int i = 0; i < 16; i++) begin
            bus_read(4'h0, v); chk("R5 kept chars", v, 32'h40 + i);
        end
        bus_read(4'h8, v); chk("R3 drop writes when full, queue drained", v, 32'h04);
        loop = 0;
    endtask

    task automatic test_errors;
        logic [31:0] v;
        send_frame(8'h5A, 0, 1);
        bus_read(4'h8, v); chk("R6 framing flag", v, 32'h45);
        bus_read(4'h0, v); chk("R6 framed char kept", v, 32'h5A);
        bus_read(4'h8, v); chk("R7 framing cleared", v, 32'h04);
        send_frame(8'h33, 1, 0);
        bus_read(4'h8, v); chk("R6 parity flag", v, 32'h85);
        bus_read(4'h0, v); chk("R6 parity char kept", v, 32'h33);
        bus_read(4'h8, v); chk("R7 parity cleared", v, 32'h04);
    endtask

    task automatic test_flush;
        logic [31:0] v;
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0);
        bus_write(4'hC, 32'h02);
        bus_read(4'h8, v); chk("R8 rx flush", v, 32'h04);
        bus_read(4'h0, v); chk("R8 rx flushed read", v, 32'h0);
        for (int i = 0; i < 5; i++) bus_write(4'h4, 32'h70 + i);
        bus_read(4'h8, v); chk("R8 tx not empty before flush", v & 32'h04, 32'h0);
        bus_write(4'hC, 32'h01);
        bus_read(4'h8, v); chk("R8 tx empty after flush", v, 32'h04);
        wait_clk(FRAME + 100);
    endtask

    task automatic test_irq;
        logic [31:0] v;
        int base;
        bus_write(4'hC, 32'h10);
        bus_read(4'h8, v); chk("R9 ie mirrored", v, 32'h14);
        base = irq_cnt;
        send_frame(8'h3C, 0, 0);
        chk("R10 rx irq pulse", irq_cnt, base + 1);
        bus_read(4'h0, v); chk("R4 irq char", v, 32'h3C);
        bus_write(4'h4, 32'h99);
        wait_clk(10);
        chk("R10 tx drain irq pulse", irq_cnt, base + 2);
        wait_clk(FRAME + 100);
        bus_write(4'hC, 32'h00);
        bus_read(4'h8, v); chk("R9 ie cleared", v, 32'h04);
        send_frame(8'h3D, 0, 0);
        chk("R10 no irq when disabled", irq_cnt, base + 2);
        bus_read(4'h0, v); chk("R4 char while disabled", v, 32'h3D);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        finish_run();
    end

    initial begin
        wait_clk(3);
        rst_n = 1;
        wait_clk(2);
        test_reset();
        test_frame_out();
        test_order();
        test_full_overrun();
        test_errors();
        test_flush();
        test_irq();
        finish_run();
    end
endmodule